// File: doc/BRIEF.md
# Per-Channel DAC Sample FIFO Controller

This block sits in one output channel of a multi-channel DAC board. A host places 16-bit samples into a 128-entry buffer through a small write port. It sets the channel's behaviour through an 8-bit control register, and the same port reads that register back with the empty flag merged in. A conversion tick comes from the channel's rate timer. On each tick the block updates the sample that the serializer toward the converter picks up.

There are two output behaviours. In hold mode each tick re-presents the newest accepted sample, which gives a fixed voltage. In stepping mode each tick takes the oldest stored sample and frees its slot, so a buffered waveform plays out. When the stepping mode meets an empty buffer, the last value stays on the output and a sticky underrun bit is set.

A refill request is raised while the fill level is below a threshold chosen by a 2-bit code. The request can be switched on and off by an enable bit. A per-channel soft clear input returns the whole channel to its power-up state.

Top module: `dac_chan_fifo`

## Requirements
- R1: After reset the channel shows level 0, empty 1, full 0, irq 0, underrun 0, sample 0, and the status byte reads 0x01.
- R2: A data write (`wr_sel_i`=1) that is accepted stores the sample and raises the level by one. Status bit 0 reads 1 exactly when the level is 0.
- R3: When the level is 128, `full_o` is 1 and a data write with no pop in the same cycle is dropped: the level and the stored contents stay unchanged.
- R4: In stepping mode (control bits 2:1 = 01) a tick with a non-empty buffer sets `sample_o` to the oldest stored sample on the next cycle, and lowers the level by one. Samples come out in write order.
- R5: In hold mode (control bits 2:1 = 00) a tick sets `sample_o` to the most recently accepted sample and leaves the level unchanged.
- R6: In stepping mode a tick while empty leaves `sample_o` unchanged and sets `underrun_o`, which then stays set until soft clear.
- R7: Control bits 6:5 pick the refill threshold: 00 gives none, 01 gives 4, 10 gives 16, 11 gives 64. `irq_o` is 1 while the level is strictly below the threshold and bit 4 is set.
- R8: With control bit 4 clear, `irq_o` is 0 whatever the level.
- R9: A data write and a stepping pop in the same cycle leave the level unchanged. At level 128 such a write is accepted and later comes out in order.
- R10: `soft_clr_i` clears the pointers, the level, the control register, the held sample, the newest-sample register and the underrun bit.
- R11: A control write (`wr_sel_i`=0) stores bits 6:1. The status byte returns those bits, reads bit 7 as 0 and reads bit 0 as the empty flag.
- R12: Control bits 2:1 = 10 or 11 (external-trigger mode) step the buffer on each tick exactly as stepping mode does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_clr_i | input | 1 | Synchronous per-channel soft clear |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 1 | 0 = control register, 1 = sample data |
| wr_data_i | input | 16 | Write data (control uses bits 7:0) |
| tick_i | input | 1 | Conversion tick |
| status_o | output | 8 | Control/status readback |
| level_o | output | 8 | Number of stored samples |
| full_o | output | 1 | Buffer holds 128 samples |
| underrun_o | output | 1 | Sticky: stepping tick found the buffer empty |
| irq_o | output | 1 | Refill request |
| sample_o | output | 16 | Sample presented to the conversion path |

## Verification
The in-module assertions guard the invariants that hold on every cycle. The level never exceeds the depth, and a write at full with no pop leaves it unchanged. A paired write and pop keep the level steady, and a stepping tick on an empty buffer always sets the underrun bit. A request never appears without the enable bit or with the threshold code off. The bench scenarios are the only way to show data order, which sample hold mode chooses, the exact threshold boundaries, that dropped writes never reach the output, and that the wrap at full depth works.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_STEP = 2'b01,
    MODE_TRG0 = 2'b10,
    MODE_TRG1 = 2'b11
  } out_mode_e;

  typedef struct packed {
    logic [1:0] thr_code;
    logic       irq_en;
    logic       trg_dir;
    out_mode_e  mode;
  } ctrl_t;

  function automatic int unsigned thr_level(input logic [1:0] code);
    case (code)
      2'b01:   return 4;
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/dcf_ctrl_reg.sv
module dcf_ctrl_reg
  import dcf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_clr_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_q <= '0;
    else if (soft_clr_i) ctrl_q <= '0;
    else if (we_i)       ctrl_q <= ctrl_t'(wdata_i[6:1]);
  end

  assign ctrl_o = ctrl_q;

  // R10
  ctrl_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> (ctrl_o == '0));
endmodule

// File: rtl/dcf_buffer.sv
module dcf_buffer #(
  parameter int DEPTH = 128,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tick_i,
  input  logic          step_i,
  output logic [CW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          underrun_o,
  output logic [DW-1:0] sample_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] level_q;
  logic [DW-1:0] newest_q, sample_q;
  logic          underrun_q;
  logic          pop, push;

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == CW'(DEPTH));
  assign pop     = tick_i && step_i && !empty_o;
  // a pop in the same cycle frees a slot, so full does not block
  assign push    = wr_i && (!full_o || pop);

  always_ff @(posedge clk_i) begin
    if (push && !soft_clr_i) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      level_q    <= '0;
      newest_q   <= '0;
      sample_q   <= '0;
      underrun_q <= 1'b0;
    end else if (soft_clr_i) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      level_q    <= '0;
      newest_q   <= '0;
      sample_q   <= '0;
      underrun_q <= 1'b0;
    end else begin
      if (push) begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
        newest_q <= wdata_i;
      end
      if (pop) rd_ptr_q <= rd_ptr_q + 1'b1;
      if (push && !pop)      level_q <= level_q + 1'b1;
      else if (pop && !push) level_q <= level_q - 1'b1;
      if (tick_i) begin
        if (!step_i)      sample_q   <= newest_q;
        else if (pop)     sample_q   <= mem[rd_ptr_q];
        else              underrun_q <= 1'b1;
      end
    end
  end

  assign level_o    = level_q;
  assign underrun_o = underrun_q;
  assign sample_o   = sample_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));
  // R3
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && !(tick_i && step_i) && !soft_clr_i) |=> full_o);
  // R9
  pair_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tick_i && step_i && !empty_o && !soft_clr_i) |=> $stable(level_o));
  // R6
  underrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && step_i && empty_o && !soft_clr_i) |=> (underrun_o && $stable(sample_o)));
endmodule

// File: rtl/dcf_irq.sv
module dcf_irq #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_en_i,
  input  logic [1:0]    thr_code_i,
  input  logic [CW-1:0] level_i,
  output logic          irq_o
);
  logic [CW-1:0] thr;

  always_comb begin
    thr   = CW'(dcf_pkg::thr_level(thr_code_i));
    irq_o = irq_en_i && (level_i < thr);
  end

  // R8
  irq_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
  // R7
  irq_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (thr_code_i != 2'b00 && level_i < CW'(64)));
endmodule

// File: rtl/dac_chan_fifo.sv
module dac_chan_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_clr_i,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          tick_i,
  output logic [7:0]    status_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          underrun_o,
  output logic          irq_o,
  output logic [DW-1:0] sample_o
);
  ctrl_t ctrl;
  logic  empty;
  logic  step;

  dcf_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_clr_i),
    .we_i       (wr_en_i && !wr_sel_i),
    .wdata_i    (wr_data_i[7:0]),
    .ctrl_o     (ctrl)
  );

  // trigger modes step like the free-running mode; trigger source lives outside
  assign step = (ctrl.mode != MODE_HOLD);

  dcf_buffer #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_clr_i),
    .wr_i       (wr_en_i && wr_sel_i),
    .wdata_i    (wr_data_i),
    .tick_i     (tick_i),
    .step_i     (step),
    .level_o    (level_o),
    .empty_o    (empty),
    .full_o     (full_o),
    .underrun_o (underrun_o),
    .sample_o   (sample_o)
  );

  dcf_irq #(.CW(CW)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_en_i   (ctrl.irq_en),
    .thr_code_i (ctrl.thr_code),
    .level_i    (level_o),
    .irq_o      (irq_o)
  );

  assign status_o = {1'b0, ctrl, empty};

  // R2
  empty_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] == (level_o == '0));
endmodule

// File: tb/dac_chan_fifo_tb.sv
module dac_chan_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [7:0]  status;
  logic [7:0]  level;
  logic        full, underrun, irq;
  logic [15:0] sample;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_chan_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_clr_i(soft_clr),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .tick_i(tick), .status_o(status), .level_o(level), .full_o(full),
    .underrun_o(underrun), .irq_o(irq), .sample_o(sample)
  );

  // {ctrl, fill, irq_expected}
  localparam logic [16:0] VEC [10] = '{
    {8'h30, 8'd3,  1'b1}, {8'h30, 8'd4,  1'b0},
    {8'h50, 8'd15, 1'b1}, {8'h50, 8'd16, 1'b0},
    {8'h70, 8'd63, 1'b1}, {8'h70, 8'd64, 1'b0},
    {8'h10, 8'd0,  1'b0}, {8'h60, 8'd0,  1'b0},
    {8'h20, 8'd2,  1'b0}, {8'h72, 8'd0,  1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk) soft_clr = 1'b1;
    @(negedge clk) soft_clr = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_sel = sel; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 level", level, 0);
    check("R1 status", status, 8'h01);
    check("R1 full", full, 0);
    check("R1 irq", irq, 0);
    check("R1 underrun", underrun, 0);
    check("R1 sample", sample, 0);

    // threshold vectors: R7 R8 R11 R2
    foreach (VEC[i]) begin
      clr();
      wr(1'b0, {8'h00, VEC[i][16:9]});
      for (int k = 0; k < int'(VEC[i][8:1]); k++) wr(1'b1, 16'(k));
      check("R7 irq", irq, VEC[i][0]);
      check("R11 status", status, (VEC[i][16:9] & 8'h7E) | (VEC[i][8:1] == 0 ? 1 : 0));
      check("R2 level", level, VEC[i][8:1]);
    end

    // R11 bit 7
    clr();
    wr(1'b0, 16'h00FF);
    check("R11 bit7", status, 8'h7F);
    // R8 enable off at level 0 with threshold 64
    wr(1'b0, 16'h0060);
    check("R8 irq off", irq, 0);

    // R4 stepping order
    clr();
    wr(1'b0, 16'h0002);
    wr(1'b1, 16'h1111); wr(1'b1, 16'h2222); wr(1'b1, 16'h3333);
    tk();
    check("R4 first", sample, 16'h1111);
    check("R4 level", level, 2);
    tk();
    check("R4 second", sample, 16'h2222);

    // R5 hold
    clr();
    wr(1'b1, 16'hAAAA); wr(1'b1, 16'hBBBB);
    tk();
    check("R5 newest", sample, 16'hBBBB);
    check("R5 level", level, 2);

    // R6 underrun
    clr();
    wr(1'b0, 16'h0002);
    wr(1'b1, 16'h5A5A);
    tk();
    check("R6 pre", underrun, 0);
    tk();
    check("R6 hold", sample, 16'h5A5A);
    check("R6 sticky", underrun, 1);
    tk();
    check("R6 still", underrun, 1);

    // R3 full and drop
    clr();
    for (int k = 0; k < 130; k++) wr(1'b1, 16'(k + 16'h100));
    check("R3 level", level, 128);
    check("R3 full", full, 1);
    wr(1'b0, 16'h0002);
    begin
      int bad = 0;
      for (int k = 0; k < 128; k++) begin
        tk();
        if (sample != 16'(k + 16'h100)) bad++;
      end
      check("R3 drained order", bad, 0);
    end
    tk();
    check("R3 dropped not shown", sample, 16'h17F);

    // R9 paired write and pop at full
    clr();
    wr(1'b0, 16'h0002);
    for (int k = 0; k < 128; k++) wr(1'b1, 16'(k));
    @(negedge clk) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'hBEEF; tick = 1'b1; end
    @(negedge clk) begin wr_en = 1'b0; tick = 1'b0; end
    check("R9 level", level, 128);
    check("R9 sample", sample, 0);
    for (int k = 0; k < 128; k++) tk();
    check("R9 last", sample, 16'hBEEF);
    check("R9 empty", level, 0);

    // R12 trigger mode steps
    clr();
    wr(1'b0, 16'h0004);
    wr(1'b1, 16'h0A0A); wr(1'b1, 16'h0B0B);
    tk();
    check("R12 step", sample, 16'h0A0A);
    check("R12 level", level, 1);

    // R10 soft clear
    tk(); tk();
    wr(1'b0, 16'h0072);
    clr();
    check("R10 level", level, 0);
    check("R10 status", status, 8'h01);
    check("R10 underrun", underrun, 0);
    check("R10 sample", sample, 0);
    tk();
    check("R10 newest cleared", sample, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule